// File: doc/BRIEF.md
# GPIO Grouped Interrupt Controller

This block watches a wide bank of general-purpose input pins and folds them onto eight shared interrupt slots. Each slot selects one pin with a 4-bit selector. The selector picks the port and the byte lane, and the slot's own index picks the bit inside that lane. Each slot has its own trigger type, which can be a level, an edge or a forced-on condition. A mask bit decides whether the slot reaches the single interrupt line. Edge events are held until software writes a one to the slot's bit in the acknowledge register.

A simple word-wide register bus programs the trigger types, the pin selectors and the mask, accepts acknowledges, and returns the raw and masked pending status. The selected pin passes through a two-flop synchronizer before any detection, so pins from other clock domains can drive the block directly. Level slots follow the synchronized pin live. Edge slots compare the synchronized value with its previous sample.

Top module: `gpio_grp_irq`

## Requirements
- R1: Slot g (0 to 7) takes its pin from the 4-bit selector field at bits 4g+3:4g of the select register (address 124). The source is bit 8*(sel mod 4)+g of port sel/4. Port p occupies bits 32p+31:32p of `pins_i`.
- R2: The trigger register (address 120) holds a 3-bit code for slot g at bits 3g+2:3g. Writes take effect on the following clock edge. The register reads back in bits 23:0, with bits 31:24 reading zero.
- R3: Code 1 (level high) makes slot g pending while the synchronized pin is 1. Code 2 (level low) makes it pending while the pin is 0. A pin change sampled at edge k shows in status after edge k+1.
- R4: Code 3 makes slot g pending regardless of its pin.
- R5: Codes 5 (rising), 6 (falling) and 7 (either) detect the matching change of the synchronized pin and hold the slot pending until it is acknowledged.
- R6: Writing address 132 with bit g set clears the held edge status of slot g. It has no lasting effect on level or forced slots. The acknowledge address reads zero.
- R7: When an edge is detected in the same cycle as an acknowledge of that slot, the slot stays pending.
- R8: Codes 0 and 4 disable a slot: it never reports pending, and any held edge status is dropped.
- R9: The mask register (address 128, bits 7:0) gates each slot. Address 140 returns raw status AND mask in bits 7:0, with upper bits zero.
- R10: `irq_o` is 1 exactly when the masked status is nonzero.
- R11: Address 136 returns the unmasked pending bits of all eight slots in bits 7:0.
- R12: Synchronous reset clears the trigger, select and mask registers and all detection state. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PORTS*PORT_W | Sampled pin levels, port p at bits 32p+31:32p |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge reaching the detector in exactly the cycle in which software acknowledges that slot. The pin change has to be placed two clock edges ahead of the acknowledge write so that it leaves the synchronizer at the right moment. The bench schedules this directly. It also runs a long random phase in which pins, trigger codes (including the reserved code), selectors, masks and acknowledges change together, and a behavioural model is compared with the read bus and the interrupt line on every cycle.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;

    localparam int NUM_SLOTS = 8;
    localparam int SEL_W     = 4;
    localparam int TRIG_W    = 3;

    localparam logic [7:0] A_TRIG   = 8'd120;
    localparam logic [7:0] A_SEL    = 8'd124;
    localparam logic [7:0] A_MASK   = 8'd128;
    localparam logic [7:0] A_ACK    = 8'd132;
    localparam logic [7:0] A_RAW    = 8'd136;
    localparam logic [7:0] A_MASKED = 8'd140;

    typedef enum logic [TRIG_W-1:0] {
        TRG_OFF  = 3'd0,
        TRG_HIGH = 3'd1,
        TRG_LOW  = 3'd2,
        TRG_SET  = 3'd3,
        TRG_RSV  = 3'd4,
        TRG_RISE = 3'd5,
        TRG_FALL = 3'd6,
        TRG_ANY  = 3'd7
    } trig_e;

    typedef struct packed {
        trig_e            trig;
        logic [SEL_W-1:0] sel;
    } slot_cfg_t;

    function automatic logic trig_is_edge(trig_e t);
        return (t == TRG_RISE) || (t == TRG_FALL) || (t == TRG_ANY);
    endfunction

endpackage

// File: rtl/gpio_grp_sync.sv
module gpio_grp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_grp_regs.sv
module gpio_grp_regs
    import gpio_grp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [7:0]           addr,
    input  logic [31:0]          wdata,
    input  logic [NUM_SLOTS-1:0] raw_i,
    output slot_cfg_t            cfg_o [NUM_SLOTS],
    output logic [NUM_SLOTS-1:0] mask_o,
    output logic [NUM_SLOTS-1:0] ack_o,
    output logic [31:0]          rdata
);
    localparam int TRIG_BITS = NUM_SLOTS * TRIG_W;
    localparam int SEL_BITS  = NUM_SLOTS * SEL_W;

    logic [TRIG_BITS-1:0]  trig_q;
    logic [SEL_BITS-1:0]   sel_q;
    logic [NUM_SLOTS-1:0]  mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            sel_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (addr == A_TRIG) trig_q <= wdata[TRIG_BITS-1:0];
            if (addr == A_SEL)  sel_q  <= wdata[SEL_BITS-1:0];
            if (addr == A_MASK) mask_q <= wdata[NUM_SLOTS-1:0];
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign cfg_o[g].trig = trig_e'(trig_q[g*TRIG_W +: TRIG_W]);
        assign cfg_o[g].sel  = sel_q[g*SEL_W +: SEL_W];
    end

    assign mask_o = mask_q;
    assign ack_o  = (wr_en && addr == A_ACK) ? wdata[NUM_SLOTS-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (addr)
            A_TRIG:   rdata[TRIG_BITS-1:0] = trig_q;
            A_SEL:    rdata[SEL_BITS-1:0]  = sel_q;
            A_MASK:   rdata[NUM_SLOTS-1:0] = mask_q;
            A_RAW:    rdata[NUM_SLOTS-1:0] = raw_i;
            A_MASKED: rdata[NUM_SLOTS-1:0] = raw_i & mask_q;
            default:  rdata = '0;
        endcase
    end

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (trig_q == '0 && sel_q == '0 && mask_q == '0));

    // R6
    ack_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == A_ACK) |-> (rdata == 32'd0));
endmodule

// File: rtl/gpio_grp_slot.sv
module gpio_grp_slot
    import gpio_grp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 32,
    parameter int SLOT_IDX  = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
    input  slot_cfg_t                   cfg_i,
    input  logic                        ack_i,
    output logic                        raw_o
);
    localparam int PIN_TOT = NUM_PORTS * PORT_W;

    logic pin_sel, pin_s, prev_q, edge_hit, lat_q, edge_mode;

    always_comb begin
        int port_i, bit_i;
        port_i  = int'(cfg_i.sel[3:2]);
        bit_i   = 8 * int'(cfg_i.sel[1:0]) + SLOT_IDX;
        pin_sel = 1'b0;
        if (port_i < NUM_PORTS && bit_i < PORT_W)
            pin_sel = pins_i[port_i*PORT_W + bit_i];
    end

    gpio_grp_sync #(.STAGES(2)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (pin_sel),
        .q_o (pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_s;
    end

    assign edge_mode = trig_is_edge(cfg_i.trig);

    always_comb begin
        case (cfg_i.trig)
            TRG_RISE: edge_hit = pin_s & ~prev_q;
            TRG_FALL: edge_hit = ~pin_s & prev_q;
            TRG_ANY:  edge_hit = pin_s ^ prev_q;
            default:  edge_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !edge_mode) lat_q <= 1'b0;
        else if (edge_hit)     lat_q <= 1'b1;
        else if (ack_i)        lat_q <= 1'b0;
    end

    always_comb begin
        case (cfg_i.trig)
            TRG_HIGH: raw_o = pin_s;
            TRG_LOW:  raw_o = ~pin_s;
            TRG_SET:  raw_o = 1'b1;
            TRG_RISE, TRG_FALL, TRG_ANY: raw_o = lat_q;
            default:  raw_o = 1'b0;
        endcase
    end

    // R5
    edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && lat_q && !ack_i) |=> lat_q);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && lat_q && ack_i && !edge_hit) |=> !lat_q);

    // R7
    edge_beats_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && edge_hit) |=> lat_q);

    // R8
    disabled_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_mode |=> !lat_q);
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
    import gpio_grp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
    input  logic                        wr_en,
    input  logic [7:0]                  addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic                        irq_o
);
    slot_cfg_t            cfg   [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] mask, ack, raw;

    gpio_grp_regs regs_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .raw_i  (raw),
        .cfg_o  (cfg),
        .mask_o (mask),
        .ack_o  (ack),
        .rdata  (rdata)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        gpio_grp_slot #(
            .NUM_PORTS (NUM_PORTS),
            .PORT_W    (PORT_W),
            .SLOT_IDX  (g)
        ) slot_i (
            .clk    (clk),
            .rst    (rst),
            .pins_i (pins_i),
            .cfg_i  (cfg[g]),
            .ack_i  (ack[g]),
            .raw_o  (raw[g])
        );
    end

    assign irq_o = |(raw & mask);

    // R10
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask != '0));

    // R9
    masked_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == A_MASKED) |-> ((rdata[NUM_SLOTS-1:0] & ~mask) == '0 && rdata[31:NUM_SLOTS] == '0));
endmodule

// File: tb/gpio_grp_irq_tb_top.sv
module gpio_grp_irq_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] pins = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = 8'd0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    gpio_grp_irq dut_i (
        .clk(clk), .rst(rst), .pins_i(pins), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    // behavioural reference
    int m_trig [8];
    int m_sel  [8];
    int m_mask;
    bit m_s1 [8], m_s2 [8], m_prev [8], m_lat [8];

    function automatic bit m_raw_bit(int g);
        case (m_trig[g])
            1: return m_s2[g];
            2: return !m_s2[g];
            3: return 1'b1;
            5, 6, 7: return m_lat[g];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int m_raw();
        int r = 0;
        for (int g = 0; g < 8; g++) if (m_raw_bit(g)) r |= (1 << g);
        return r;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        int v = 0;
        case (a)
            8'd120: for (int g = 0; g < 8; g++) v |= (m_trig[g] << (3*g));
            8'd124: for (int g = 0; g < 8; g++) v |= (m_sel[g] << (4*g));
            8'd128: v = m_mask;
            8'd136: v = m_raw();
            8'd140: v = m_raw() & m_mask;
            default: v = 0;
        endcase
        return 32'(v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < 8; g++) begin
                m_trig[g] = 0; m_sel[g] = 0;
                m_s1[g] = 0; m_s2[g] = 0; m_prev[g] = 0; m_lat[g] = 0;
            end
            m_mask = 0;
        end else begin
            for (int g = 0; g < 8; g++) begin
                bit hit, ackb, edge_m;
                int idx;
                edge_m = (m_trig[g] >= 5);
                hit = (m_trig[g] == 5 && m_s2[g] && !m_prev[g]) ||
                      (m_trig[g] == 6 && !m_s2[g] && m_prev[g]) ||
                      (m_trig[g] == 7 && m_s2[g] != m_prev[g]);
                ackb = wr_en && addr == 8'd132 && wdata[g];
                if (!edge_m) m_lat[g] = 0;
                else if (hit) m_lat[g] = 1;
                else if (ackb) m_lat[g] = 0;
                idx = (m_sel[g] / 4) * 32 + 8 * (m_sel[g] % 4) + g;
                m_prev[g] = m_s2[g];
                m_s2[g]   = m_s1[g];
                m_s1[g]   = pins[idx];
            end
            if (wr_en) begin
                if (addr == 8'd120) for (int g = 0; g < 8; g++) m_trig[g] = int'(wdata[3*g +: 3]);
                if (addr == 8'd124) for (int g = 0; g < 8; g++) m_sel[g] = int'(wdata[4*g +: 4]);
                if (addr == 8'd128) m_mask = int'(wdata[7:0]);
            end
        end
    end

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'd136: return "R11";
            8'd140: return "R9";
            8'd132: return "R6";
            default: return "R12";
        endcase
    endfunction

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            logic [31:0] er;
            bit ei;
            er = m_read(addr);
            ei = ((m_raw() & m_mask) != 0);
            total++;
            if (rdata !== er) begin
                bad++;
                $display("FAIL %s addr=%0d rdata=%h expected=%h", tag_of(addr), addr, rdata, er);
            end
            total++;
            if (irq_o !== ei) begin
                bad++;
                $display("FAIL R10 irq=%b expected=%b", irq_o, ei);
            end
        end
    end

    task automatic chk(string tag, logic [7:0] a);
        @(negedge clk);
        addr = a;
        #1;
        total++;
        if (rdata !== m_read(a)) begin
            bad++;
            $display("FAIL %s addr=%0d rdata=%h expected=%h", tag, a, rdata, m_read(a));
        end
    endtask

    task automatic chk_val(string tag, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d rdata=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] trig_word(int c0, int c1, int c2, int c3,
                                                int c4, int c5, int c6, int c7);
        return 32'((c0) | (c1 << 3) | (c2 << 6) | (c3 << 9) |
                   (c4 << 12) | (c5 << 15) | (c6 << 18) | (c7 << 21));
    endfunction

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R12: reset state
        chk_val("R12", 8'd120, 32'd0);
        chk_val("R12", 8'd124, 32'd0);
        chk_val("R12", 8'd128, 32'd0);
        chk_val("R12", 8'd100, 32'd0);

        // R1 / R3: slot 2 level high from port1 lane2 (sel=6), pin bit 32+18
        wr(8'd124, 32'h0000_0600);
        wr(8'd120, trig_word(0, 0, 1, 0, 0, 0, 0, 0));
        wr(8'd128, 32'hFF);
        @(negedge clk); pins[32+2] = 1'b1;   // wrong pin, must not count
        idle(3);
        chk_val("R1", 8'd136, 32'h0);
        @(negedge clk); pins[32+18] = 1'b1;
        idle(3);
        chk_val("R1", 8'd136, 32'h4);
        chk_val("R3", 8'd140, 32'h4);
        // R2 readback, then level low on slot 2
        wr(8'd120, trig_word(0, 0, 2, 0, 0, 0, 0, 0));
        chk_val("R2", 8'd120, 32'h0000_0080);
        chk_val("R3", 8'd136, 32'h0);
        @(negedge clk); pins[32+18] = 1'b0;
        idle(3);
        chk_val("R3", 8'd136, 32'h4);

        // R4: slot 7 always set
        wr(8'd120, trig_word(0, 0, 0, 0, 0, 0, 0, 3));
        idle(1);
        chk_val("R4", 8'd136, 32'h80);

        // R5: slot 0 rising edge, port0 bit 0
        wr(8'd124, 32'h0);
        wr(8'd120, trig_word(5, 6, 0, 0, 0, 0, 0, 0));
        idle(3);
        @(negedge clk); pins[0] = 1'b1;
        idle(2);
        @(negedge clk); pins[0] = 1'b0;
        idle(5);
        chk_val("R5", 8'd136, 32'h1);
        // R6: acknowledge clears it
        wr(8'd132, 32'h1);
        chk_val("R6", 8'd136, 32'h0);
        chk_val("R6", 8'd132, 32'h0);
        // slot 1 falling on pin 1
        @(negedge clk); pins[1] = 1'b1;
        idle(4);
        @(negedge clk); pins[1] = 1'b0;
        idle(4);
        chk_val("R5", 8'd136, 32'h2);

        // R7: edge arrives as ack is sampled
        wr(8'd132, 32'h3);
        idle(2);
        @(negedge clk); pins[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 8'd132; wdata = 32'h1;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
        chk_val("R7", 8'd136, 32'h1);
        chk("R7", 8'd140);

        // R6: ack on level slot has no lasting effect
        wr(8'd120, trig_word(1, 0, 0, 0, 0, 0, 0, 0));
        idle(2);
        wr(8'd132, 32'hFF);
        chk_val("R6", 8'd136, 32'h1);

        // R8: codes 0 and 4 stay quiet under toggling
        wr(8'd120, trig_word(4, 0, 4, 0, 4, 0, 4, 0));
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); pins = {4{$urandom()}};
        end
        idle(3);
        chk_val("R8", 8'd136, 32'h0);
        chk_val("R10", 8'd140, 32'h0);

        // random mixed phase, compared every cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            pins = {$urandom(), $urandom(), $urandom(), $urandom()};
            case ($urandom_range(0, 9))
                0: begin wr_en = 1; addr = 8'd120; wdata = $urandom(); end
                1: begin wr_en = 1; addr = 8'd124; wdata = $urandom(); end
                2: begin wr_en = 1; addr = 8'd128; wdata = $urandom(); end
                3, 4: begin wr_en = 1; addr = 8'd132; wdata = $urandom(); end
                default: begin
                    wr_en = 0;
                    addr = 8'(120 + 4 * $urandom_range(0, 6));
                end
            endcase
        end
        @(negedge clk); wr_en = 0;
        chk("R11", 8'd136);
        chk("R9", 8'd140);

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule